// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control logic of a register-rename pipeline stage. Each cycle it may receive a bundle of up to `WIDTH` instructions from decode. From the execute stage it gets a stall flag and the free issue-queue count. From the commit stage it gets a stall flag, a squash flag, a reorder-buffer-squashing flag and the free reorder-buffer count. From the physical register pool it gets the free register count. For the current bundle it decides which slots are renamed, and it reports that decision as a per-slot accept strobe. It also drives a stall back to decode.

When the stage cannot take a whole bundle, it keeps the part it has not accepted in a skid buffer of whole bundles. While the stage is blocked, every bundle that decode still delivers is also stored there. After the stall clears, an unblocking phase replays the stored bundles, oldest first, before any new decode input is renamed. A serializing instruction parks the stage in a barrier state until the reorder buffer has drained. A squash from commit discards everything held in the skid buffer.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset, `stage_o` is idle, `stall_o` is low and `accept_o` is zero. `stage_o` uses these codes: idle 0, running 1, blocked 2, unblocking 3, squashing 4, barrier 5.
- R2: In idle, running or unblocking, with no squash, an execute or commit stall gives no accept in that cycle, raises `stall_o` in that cycle and moves the stage to blocked. A valid decode bundle (bit 0 of `dec_valid`) offered in that cycle is stored in the skid buffer.
- R3: In blocked and in barrier, with no squash, nothing is accepted, `stall_o` is high, and every decode bundle with slot 0 valid is appended to the skid buffer. `stall_o` is also high in every cycle the stage spends in unblocking.
- R4: Blocked leaves when there is no execute stall, no commit stall, and both free counts are non-zero. It goes to unblocking if the skid buffer holds a bundle after this cycle's capture, and to running otherwise.
- R5: In unblocking, the working bundle is the skid head, and `from_skid_o` is high in any cycle in which that head is processed. A head that is fully accepted is removed. The stage returns to running once no bundle remains.
- R6: `accept_o` is always contiguous from slot 0. Slot i (valid bit `dec_valid[i]`) is accepted only if i < min(`free_rob`, `free_iq`). If either count is zero, nothing is accepted and the stage blocks.
- R7: The destination count of slot i is `dec_ndest[i*DEST_W +: DEST_W]`. A slot is accepted only while the running sum of destination counts over the accepted slots, up to and including it, is no more than `free_preg`. The first slot that fails this test blocks the stage.
- R8: A slot whose `dec_serial` bit is set is accepted under the normal limits, but no younger slot is accepted in that cycle. The stage then enters barrier. Barrier is left only under the R4 conditions and only when `free_rob` equals `ROB_DEPTH`.
- R9: The slots of a bundle that are not accepted keep their order. They are shifted down to start at slot 0 and are replayed during unblocking before any newer bundle.
- R10: A squash or reorder-buffer-squashing flag in any state empties the skid buffer and moves the stage to squashing. Squashing stays while either flag is high. When both flags are low, the stage goes to running without accepting anything in that cycle.
- R11: Squash takes priority over every other condition: in a squash cycle `accept_o` is zero and `stall_o` is low, even when a stall or a valid bundle is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dec_valid | input | WIDTH | Per-slot valid bits of the decode bundle, contiguous from slot 0 |
| dec_serial | input | WIDTH | Per-slot serializing flags |
| dec_ndest | input | WIDTH*DEST_W | Per-slot destination register counts |
| exe_stall | input | 1 | Stall request from execute |
| cmt_stall | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Squash from commit |
| cmt_rob_squashing | input | 1 | Reorder buffer is still squashing |
| free_rob | input | CNT_W | Free reorder-buffer entries |
| free_iq | input | CNT_W | Free issue-queue entries |
| free_preg | input | PREG_W | Free physical registers |
| accept_o | output | WIDTH | Per-slot rename accept strobe |
| from_skid_o | output | 1 | Accepted slots come from the skid head |
| stall_o | output | 1 | Stall to decode |
| stage_o | output | 3 | Current stage state |

## Verification
The assertions assume that decode never pushes a bundle into a full skid buffer. They also assume that the valid bits are contiguous from slot 0 and that the free counts never exceed their structure depths. The random stimulus keeps a model copy of the skid occupancy and offers a valid bundle only while that copy has room. It builds every bundle as a run of valid slots starting at slot 0 and draws the free counts within their depths. To reach the barrier release, it draws the full reorder-buffer count often.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RUN     = 3'd1,
      ST_BLOCK   = 3'd2,
      ST_UNBLK   = 3'd3,
      ST_SQUASH  = 3'd4,
      ST_BARRIER = 3'd5
   } stage_e;
endpackage

// File: rtl/rsc_slot_pick.sv
module rsc_slot_pick #(
   parameter int W     = 4,
   parameter int DW    = 2,
   parameter int CNT_W = 5,
   parameter int PW    = 6
) (
   input  logic [W-1:0]    v,
   input  logic [W-1:0]    s,
   input  logic [W*DW-1:0] nd,
   input  logic [CNT_W-1:0] rob,
   input  logic [CNT_W-1:0] iq,
   input  logic [PW-1:0]   preg,
   output logic [W-1:0]    acc,
   output logic [W-1:0]    rem_v,
   output logic [W-1:0]    rem_s,
   output logic [W*DW-1:0] rem_nd,
   output logic            ser_hit,
   output logic            rem_any
);
   localparam int SW = PW + DW + $clog2(W + 1);

   logic [CNT_W-1:0] lim;
   logic [SW-1:0]    sum;
   logic             stop;
   int               n;

   always_comb begin
      lim     = (rob < iq) ? rob : iq;
      acc     = '0;
      sum     = '0;
      stop    = 1'b0;
      ser_hit = 1'b0;
      n       = 0;
      for (int i = 0; i < W; i++) begin
         if (v[i] && !stop) begin
            if ((i < int'(lim)) &&
                ((sum + SW'(nd[i*DW +: DW])) <= SW'(preg))) begin
               acc[i] = 1'b1;
               sum    = sum + SW'(nd[i*DW +: DW]);
               n      = i + 1;
               if (s[i]) begin
                  ser_hit = 1'b1;
                  stop    = 1'b1;
               end
            end else begin
               stop = 1'b1;
            end
         end
      end
      rem_v  = '0;
      rem_s  = '0;
      rem_nd = '0;
      for (int j = 0; j < W; j++) begin
         for (int k = 0; k < W; k++) begin
            if (k == j + n) begin
               rem_v[j]            = v[k];
               rem_s[j]            = s[k];
               rem_nd[j*DW +: DW]  = nd[k*DW +: DW];
            end
         end
      end
      rem_any = |rem_v;
   end
endmodule

// File: rtl/rsc_skid.sv
module rsc_skid #(
   parameter int DEPTH = 4,
   parameter int EW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [EW-1:0] push_d,
   input  logic          pop,
   input  logic          hwr,
   input  logic [EW-1:0] hwr_d,
   output logic [EW-1:0] head_d,
   output logic [$clog2(DEPTH+1)-1:0] cnt
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNTW = $clog2(DEPTH + 1);

   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] rd_p, wr_p;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else if (flush) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         if (push) wr_p <= bump(wr_p);
         if (pop)  rd_p <= bump(rd_p);
         cnt <= cnt + CNTW'(push) - CNTW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (push) mem[wr_p] <= push_d;
         if (hwr && !pop) mem[rd_p] <= hwr_d;
      end
   end

   assign head_d = mem[rd_p];
endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl #(
   parameter int WIDTH      = 4,
   parameter int DEST_W     = 2,
   parameter int ROB_DEPTH  = 16,
   parameter int IQ_DEPTH   = 16,
   parameter int PREG_W     = 6,
   parameter int SKID_DEPTH = 4,
   localparam int CNT_W = $clog2(((ROB_DEPTH > IQ_DEPTH) ? ROB_DEPTH : IQ_DEPTH) + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WIDTH-1:0]         dec_valid,
   input  logic [WIDTH-1:0]         dec_serial,
   input  logic [WIDTH*DEST_W-1:0]  dec_ndest,
   input  logic                     exe_stall,
   input  logic                     cmt_stall,
   input  logic                     cmt_squash,
   input  logic                     cmt_rob_squashing,
   input  logic [CNT_W-1:0]         free_rob,
   input  logic [CNT_W-1:0]         free_iq,
   input  logic [PREG_W-1:0]        free_preg,
   output logic [WIDTH-1:0]         accept_o,
   output logic                     from_skid_o,
   output logic                     stall_o,
   output logic [2:0]               stage_o
);
   import rsc_pkg::*;

   localparam int EW   = 2 * WIDTH + WIDTH * DEST_W;
   localparam int CNTW = $clog2(SKID_DEPTH + 1);

   if (WIDTH < 1) begin : g_bad_width
      $error("WIDTH must be at least 1");
   end
   if (SKID_DEPTH < 1) begin : g_bad_depth
      $error("SKID_DEPTH must be at least 1");
   end
   if (DEST_W < 1) begin : g_bad_dest
      $error("DEST_W must be at least 1");
   end

   stage_e state, nxt;

   logic [EW-1:0]   dec_pack, work, skid_head, rem_pack;
   logic [CNTW-1:0] skid_cnt;
   logic            skid_push, skid_pop, skid_hwr, skid_flush;
   logic [EW-1:0]   skid_push_d;
   logic [WIDTH-1:0] acc, rem_v, rem_s;
   logic [WIDTH*DEST_W-1:0] rem_nd;
   logic            ser_hit, rem_any;
   logic            sq, ext, dec_has, release_ok, blk;

   assign dec_pack = {dec_ndest, dec_serial, dec_valid};
   assign work     = (state == ST_UNBLK) ? skid_head : dec_pack;
   assign rem_pack = {rem_nd, rem_s, rem_v};

   rsc_slot_pick #(.W(WIDTH), .DW(DEST_W), .CNT_W(CNT_W), .PW(PREG_W)) u_pick (
      .v       (work[WIDTH-1:0]),
      .s       (work[2*WIDTH-1:WIDTH]),
      .nd      (work[EW-1:2*WIDTH]),
      .rob     (free_rob),
      .iq      (free_iq),
      .preg    (free_preg),
      .acc     (acc),
      .rem_v   (rem_v),
      .rem_s   (rem_s),
      .rem_nd  (rem_nd),
      .ser_hit (ser_hit),
      .rem_any (rem_any)
   );

   rsc_skid #(.DEPTH(SKID_DEPTH), .EW(EW)) u_skid (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (skid_flush),
      .push   (skid_push),
      .push_d (skid_push_d),
      .pop    (skid_pop),
      .hwr    (skid_hwr),
      .hwr_d  (rem_pack),
      .head_d (skid_head),
      .cnt    (skid_cnt)
   );

   assign sq         = cmt_squash | cmt_rob_squashing;
   assign ext        = exe_stall | cmt_stall;
   assign dec_has    = dec_valid[0];
   assign release_ok = !ext && (free_rob != '0) && (free_iq != '0) &&
                       ((state == ST_BLOCK) || (free_rob == CNT_W'(ROB_DEPTH)));
   assign blk        = ser_hit | rem_any;

   always_comb begin
      nxt         = state;
      accept_o    = '0;
      from_skid_o = 1'b0;
      stall_o     = 1'b0;
      skid_flush  = 1'b0;
      skid_push   = 1'b0;
      skid_push_d = dec_pack;
      skid_pop    = 1'b0;
      skid_hwr    = 1'b0;
      if (sq) begin
         skid_flush = 1'b1;
         nxt        = ST_SQUASH;
      end else begin
         case (state)
            ST_SQUASH: nxt = ST_RUN;
            ST_BLOCK, ST_BARRIER: begin
               stall_o   = 1'b1;
               skid_push = dec_has;
               if (release_ok)
                  nxt = ((skid_cnt != '0) || dec_has) ? ST_UNBLK : ST_RUN;
            end
            default: begin
               if (ext) begin
                  stall_o   = 1'b1;
                  skid_push = dec_has;
                  nxt       = ST_BLOCK;
               end else if ((state == ST_UNBLK) || dec_has) begin
                  accept_o    = acc;
                  from_skid_o = (state == ST_UNBLK);
                  stall_o     = (state == ST_UNBLK) | blk;
                  if (state == ST_UNBLK) begin
                     skid_push = dec_has;
                     skid_hwr  = rem_any;
                     skid_pop  = !rem_any;
                  end else begin
                     skid_push   = rem_any;
                     skid_push_d = rem_pack;
                  end
                  if (blk)
                     nxt = ser_hit ? ST_BARRIER : ST_BLOCK;
                  else if (state == ST_UNBLK)
                     nxt = ((skid_cnt == CNTW'(1)) && !dec_has) ? ST_RUN : ST_UNBLK;
                  else
                     nxt = ST_RUN;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign stage_o = state;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
   parameter int W     = 4,
   parameter int CNT_W = 5,
   parameter int DEPTH = 4,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmt_squash,
   input logic             cmt_rob_squashing,
   input logic             exe_stall,
   input logic             cmt_stall,
   input logic [CNT_W-1:0] free_rob,
   input logic [CNT_W-1:0] free_iq,
   input logic [W-1:0]     accept_o,
   input logic             stall_o,
   input logic [2:0]       stage_o,
   input logic             skid_push,
   input logic             skid_pop,
   input logic [CNTW-1:0]  skid_cnt
);
   logic sq;
   assign sq = cmt_squash | cmt_rob_squashing;

   // R10
   squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq |=> (stage_o == 3'd4));

   // R11
   squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq |-> (accept_o == '0 && !stall_o));

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq && (stage_o == 3'd2 || stage_o == 3'd3 || stage_o == 3'd5)) |-> stall_o);

   // R6
   acc_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o & (accept_o + W'(1))) == '0);

   // R6
   acc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(accept_o) <= int'(free_rob)) && ($countones(accept_o) <= int'(free_iq)));

   // R2
   ext_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq && (exe_stall || cmt_stall) &&
       (stage_o == 3'd0 || stage_o == 3'd1 || stage_o == 3'd3)) |=> (stage_o == 3'd2));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(skid_push && !skid_pop && skid_cnt == CNTW'(DEPTH)));
endmodule

bind rename_stall_ctrl rsc_chk #(.W(WIDTH), .CNT_W(CNT_W), .DEPTH(SKID_DEPTH)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .cmt_squash        (cmt_squash),
   .cmt_rob_squashing (cmt_rob_squashing),
   .exe_stall         (exe_stall),
   .cmt_stall         (cmt_stall),
   .free_rob          (free_rob),
   .free_iq           (free_iq),
   .accept_o          (accept_o),
   .stall_o           (stall_o),
   .stage_o           (stage_o),
   .skid_push         (skid_push),
   .skid_pop          (skid_pop),
   .skid_cnt          (skid_cnt)
);

// File: tb/tb_rename_stall_ctrl.sv
module tb_rename_stall_ctrl;
   localparam int W     = 4;
   localparam int DW    = 2;
   localparam int ROBD  = 16;
   localparam int IQD   = 16;
   localparam int PW    = 6;
   localparam int DEPTH = 4;
   localparam int CW    = $clog2(((ROBD > IQD) ? ROBD : IQD) + 1);
   localparam int EW    = 2 * W + W * DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0]    dec_valid = '0, dec_serial = '0;
   logic [W*DW-1:0] dec_ndest = '0;
   logic exe_stall = 1'b0, cmt_stall = 1'b0, cmt_squash = 1'b0, cmt_rob_squashing = 1'b0;
   logic [CW-1:0] free_rob = '0, free_iq = '0;
   logic [PW-1:0] free_preg = '0;
   logic [W-1:0]  accept_o;
   logic from_skid_o, stall_o;
   logic [2:0] stage_o;

   int errors = 0, checks = 0, cycles = 0;
   bit done = 1'b0;

   int st = 0;
   logic [EW-1:0] q [$];

   always #2 clk = ~clk;

   rename_stall_ctrl #(.WIDTH(W), .DEST_W(DW), .ROB_DEPTH(ROBD), .IQ_DEPTH(IQD),
                       .PREG_W(PW), .SKID_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_serial(dec_serial),
      .dec_ndest(dec_ndest), .exe_stall(exe_stall), .cmt_stall(cmt_stall),
      .cmt_squash(cmt_squash), .cmt_rob_squashing(cmt_rob_squashing),
      .free_rob(free_rob), .free_iq(free_iq), .free_preg(free_preg),
      .accept_o(accept_o), .from_skid_o(from_skid_o), .stall_o(stall_o), .stage_o(stage_o));

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cycles);
      end
   endtask

   function automatic void pick(input logic [EW-1:0] b, input int rob, input int iq,
                                input int preg, output logic [W-1:0] acc,
                                output logic [EW-1:0] rem, output bit ser, output bit plim);
      logic [W-1:0] v, s, rv, rs;
      logic [W*DW-1:0] nd, rn;
      int lim, sum, n;
      bit stop;
      v = b[W-1:0]; s = b[2*W-1:W]; nd = b[EW-1:2*W];
      lim = (rob < iq) ? rob : iq;
      acc = '0; sum = 0; n = 0; stop = 0; ser = 0; plim = 0;
      for (int i = 0; i < W; i++) begin
         if (v[i] && !stop) begin
            if (i < lim && sum + int'(nd[i*DW +: DW]) <= preg) begin
               acc[i] = 1'b1; sum += int'(nd[i*DW +: DW]); n = i + 1;
               if (s[i]) begin ser = 1; stop = 1; end
            end else begin
               if (i < lim) plim = 1;
               stop = 1;
            end
         end
      end
      rv = '0; rs = '0; rn = '0;
      for (int j = 0; j + n < W; j++) begin
         rv[j] = v[j+n]; rs[j] = s[j+n]; rn[j*DW +: DW] = nd[(j+n)*DW +: DW];
      end
      rem = {rn, rs, rv};
   endfunction

   task automatic model_step();
      logic [W-1:0] e_acc;
      logic [EW-1:0] dec, work, rem;
      bit e_stall, e_fs, ser, plim, sq, ext, dv, remany, rel;
      int nxt;
      string tag;
      e_acc = '0; e_stall = 0; e_fs = 0; nxt = st; tag = "R6";
      dec = {dec_ndest, dec_serial, dec_valid};
      dv  = dec_valid[0];
      sq  = cmt_squash | cmt_rob_squashing;
      ext = exe_stall | cmt_stall;
      if (sq) begin
         tag = (ext || dv) ? "R11" : "R10";
         q.delete(); nxt = 4;
      end else if (st == 4) begin
         tag = "R10"; nxt = 1;
      end else if (st == 2 || st == 5) begin
         e_stall = 1;
         tag = (st == 5) ? "R8" : "R3";
         if (dv) q.push_back(dec);
         rel = !ext && free_rob != 0 && free_iq != 0 && (st == 2 || int'(free_rob) == ROBD);
         if (rel) begin
            tag = (st == 5) ? "R8" : "R4";
            nxt = (q.size() != 0) ? 3 : 1;
         end
      end else if (ext) begin
         tag = "R2"; e_stall = 1; nxt = 2;
         if (dv) q.push_back(dec);
      end else if (st == 3 || dv) begin
         work = (st == 3) ? q[0] : dec;
         pick(work, int'(free_rob), int'(free_iq), int'(free_preg), e_acc, rem, ser, plim);
         remany = |rem[W-1:0];
         if (st == 3) tag = "R5";
         if (remany) tag = "R9";
         if (plim) tag = "R7";
         if (ser) tag = "R8";
         e_fs = (st == 3);
         e_stall = (st == 3) || ser || remany;
         if (st == 3) begin
            if (remany) q[0] = rem; else void'(q.pop_front());
            if (dv) q.push_back(dec);
         end else if (remany) q.push_back(rem);
         if (ser || remany) nxt = ser ? 5 : 2;
         else if (st == 3) nxt = (q.size() == 0) ? 1 : 3;
         else nxt = 1;
      end
      chk(accept_o == e_acc, tag, "accept", int'(accept_o), int'(e_acc));
      chk(stall_o == e_stall, tag, "stall", int'(stall_o), int'(e_stall));
      chk(from_skid_o == e_fs, "R5", "from_skid", int'(from_skid_o), int'(e_fs));
      st = nxt;
   endtask

   task automatic cyc(logic [W-1:0] v, logic [W-1:0] s, logic [W*DW-1:0] nd,
                      bit es, bit cs, bit sqv, bit rs, int rob, int iq, int preg);
      @(negedge clk);
      dec_valid = v; dec_serial = s; dec_ndest = nd;
      exe_stall = es; cmt_stall = cs; cmt_squash = sqv; cmt_rob_squashing = rs;
      free_rob = CW'(rob); free_iq = CW'(iq); free_preg = PW'(preg);
      #1;
      chk(int'(stage_o) == st, "R1", "stage", int'(stage_o), st);
      model_step();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      #1;
      chk(stage_o == 3'd0, "R1", "reset stage", int'(stage_o), 0);
      chk(stall_o == 1'b0, "R1", "reset stall", int'(stall_o), 0);
      chk(accept_o == '0, "R1", "reset accept", int'(accept_o), 0);
      rst_n = 1'b1;
      // R6 full bundle, ample resources
      cyc(4'hF, 4'h0, 8'h55, 0, 0, 0, 0, 16, 16, 40);
      // R6 capped by reorder-buffer count, remainder kept (R9)
      cyc(4'hF, 4'h0, 8'h00, 0, 0, 0, 0, 2, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      // R7 register pool limits the bundle
      cyc(4'h7, 4'h0, 8'h2A, 0, 0, 0, 0, 16, 16, 4);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      // R11 squash beats stall and valid bundle
      cyc(4'h3, 4'h0, 8'h00, 1, 1, 1, 0, 0, 0, 0);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 1, 16, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      // R8 serializing slot then barrier release at full reorder buffer
      cyc(4'hF, 4'h2, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      cyc(4'h1, 4'h0, 8'h01, 0, 0, 0, 0, 10, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      cyc(4'h0, 4'h0, 8'h00, 0, 0, 0, 0, 16, 16, 40);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [W-1:0] v, s;
         logic [W*DW-1:0] nd;
         int nv, rob, iq;
         bit es, cs, sqv, rs;
         nv = int'($urandom_range(0, W));
         if (q.size() >= DEPTH) nv = 0;
         v = '0; s = '0; nd = '0;
         for (int i = 0; i < nv; i++) begin
            v[i] = 1'b1;
            s[i] = ($urandom_range(0, 99) < 6);
            nd[i*DW +: DW] = DW'($urandom_range(0, 2));
         end
         es  = ($urandom_range(0, 99) < 8);
         cs  = ($urandom_range(0, 99) < 5);
         sqv = ($urandom_range(0, 99) < 3);
         rs  = ($urandom_range(0, 99) < 3);
         rob = ($urandom_range(0, 99) < 30) ? ROBD : int'($urandom_range(0, ROBD));
         iq  = int'($urandom_range(0, IQD));
         cyc(v, s, nd, es, cs, sqv, rs, rob, iq, int'($urandom_range(0, 8)));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule